// File: doc/BRIEF.md
# OFDM Guard-Interval Postfix and Edge Window Unit

This unit sits behind a 64-point inverse transform in an OFDM transmitter. It takes the time-domain samples of each symbol and produces the extended symbol with its guard interval. The transform is fed with samples that are already rotated, so the guard is built as a postfix. The unit keeps the opening 16 samples of each 64-sample symbol in a small buffer while it forwards them. Once all 64 have gone out, it plays those 16 again. Each symbol therefore leaves as 80 samples, and no full-symbol delay line is needed. While the replay runs, the unit holds off the upstream source.

Consecutive symbols are joined with a one-sample overlap window. The opening output sample of every symbol is the average of that sample and the sample that would have continued the previous symbol. After the final symbol of a frame, the unit appends one extra sample: half of that continuation value. Training symbols of 16 samples use the same path. Each is forwarded with no replay, and the sample that continues it is its own opening sample.

Each input sample carries a start-of-symbol flag. The short-symbol and last-in-frame flags are read only on that opening sample. The output is a valid/ready stream with back-pressure.

Top module: `gi_postfix_window`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1 while out_ready is 1.
- R2: A long symbol (in_short=0 on its start sample) of 64 samples is emitted as 80 samples: its 64 input samples in order, then its input samples 0..15 in order, with no sample lost under back-pressure.
- R3: After the 64th sample of a long symbol is accepted, in_ready stays 0 for exactly 16 cycles when out_ready is held at 1, and only then is the next symbol taken.
- R4: The first output sample of each symbol is floor((x0 + c)/2) per component, where x0 is the symbol's input sample 0 and c is the previous symbol's continuation value. The sum is formed in 17 bits, so full-scale inputs do not wrap.
- R5: The continuation value of a long symbol is its input sample 16. That of a short symbol is its input sample 0.
- R6: For the first symbol after reset or after a frame's last symbol, the continuation value used by the window is 0.
- R7: After the last symbol of a frame (in_last=1 on its start sample), one extra output floor(c/2) is appended. For a long last symbol this makes in_ready stay 0 for 17 cycles in total.
- R8: A short symbol is 16 samples, emitted once with no replay and with no stall of in_ready after it.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_re and out_im hold. in_ready is never 1 while the output register is full and not being drained.
- R10: in_short and in_last are ignored on samples whose in_sos is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Unit takes the input sample this cycle |
| in_sos | input | 1 | Sample is index 0 of a symbol |
| in_short | input | 1 | On a start sample: symbol is a 16-sample training symbol |
| in_last | input | 1 | On a start sample: symbol is the last of its frame |
| in_re | input | 16 | Input real part, two's complement |
| in_im | input | 16 | Input imaginary part, two's complement |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output sample |
| out_re | output | 16 | Output real part, two's complement |
| out_im | output | 16 | Output imaginary part, two's complement |

## Verification
The bench targets the stall length at each symbol boundary: 16 cycles after a long symbol, 17 after a long last symbol, none after a short one. A controller that miscounts the replay or skips the tail state shows up there as a wrong count. Window values are driven at full scale in both signs, so a 16-bit sum that wraps gives a wrong sign or magnitude in the opening sample or the tail. The continuation value changes source between long symbols (sample 16) and short symbols (sample 0), and a mixed sequence exposes a unit that takes it from the wrong place. Random back-pressure and random flags on non-start samples show up lost or duplicated samples, and symbols that take their mode from the wrong sample.

// File: rtl/gpw_pkg.sv
`timescale 1ns/1ps
package gpw_pkg;

  typedef enum logic [1:0] {
    ST_PASS   = 2'd0,
    ST_REPLAY = 2'd1,
    ST_TAIL   = 2'd2
  } gpw_state_e;

  typedef enum logic [1:0] {
    SEL_IN   = 2'd0,
    SEL_WIN  = 2'd1,
    SEL_BUF  = 2'd2,
    SEL_TAIL = 2'd3
  } gpw_sel_e;

endpackage

// File: rtl/gpw_half_sum.sv
`timescale 1ns/1ps
// Average of two signed samples: widened sum, arithmetic shift by one.
module gpw_half_sum #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [W:0] sum;

  assign sum = {a[W-1], a} + {b[W-1], b};
  assign y   = sum[W:1];
endmodule

// File: rtl/gpw_gi_buf.sv
`timescale 1ns/1ps
// Guard-interval sample store: one write port, one read port.
module gpw_gi_buf #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic hit;
    assign hit = we && (waddr == AW'(e));
    always_ff @(posedge clk) begin
      if (hit) begin
        mem[e] <= wdata;
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/gpw_ctrl.sv
`timescale 1ns/1ps
// Symbol sequencer: forward, replay, tail.
module gpw_ctrl
  import gpw_pkg::*;
#(
  parameter int SYM_LEN   = 64,
  parameter int GI_LEN    = 16,
  parameter int SHORT_LEN = 16,
  localparam int CNT_W = $clog2(SYM_LEN),
  localparam int GI_W  = $clog2(GI_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_sos,
  input  logic            in_short,
  input  logic            in_last,
  input  logic            adv,
  output logic            in_ready,
  output logic            emit,
  output gpw_sel_e        sel,
  output logic            buf_we,
  output logic [GI_W-1:0] buf_waddr,
  output logic [GI_W-1:0] buf_raddr,
  output logic            cap_cur,
  output logic            load_prev,
  output logic            clr_prev
);
  localparam logic [CNT_W-1:0] LONG_END  = CNT_W'(SYM_LEN - 1);
  localparam logic [CNT_W-1:0] SHORT_END = CNT_W'(SHORT_LEN - 1);
  localparam logic [CNT_W-1:0] CAP_IDX   = CNT_W'(GI_LEN);
  localparam logic [GI_W-1:0]  GI_END    = GI_W'(GI_LEN - 1);

  gpw_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GI_W-1:0]  rcnt_q, rcnt_d;
  logic             short_q, short_d;
  logic             last_q, last_d;

  logic [CNT_W-1:0] eff_idx;
  logic             eff_short;
  logic             eff_last;
  logic             acc;
  logic             at_end;

  assign in_ready  = (state_q == ST_PASS) && adv;
  assign eff_idx   = in_sos ? '0 : cnt_q;
  assign eff_short = in_sos ? in_short : short_q;
  assign eff_last  = in_sos ? in_last : last_q;
  assign acc       = in_valid && in_ready;
  assign at_end    = (eff_idx == (eff_short ? SHORT_END : LONG_END));
  assign buf_waddr = eff_idx[GI_W-1:0];
  assign buf_raddr = rcnt_q;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    rcnt_d    = rcnt_q;
    short_d   = short_q;
    last_d    = last_q;
    emit      = 1'b0;
    sel       = SEL_IN;
    buf_we    = 1'b0;
    cap_cur   = 1'b0;
    load_prev = 1'b0;
    clr_prev  = 1'b0;
    unique case (state_q)
      ST_PASS: begin
        emit = in_valid;
        sel  = (eff_idx == '0) ? SEL_WIN : SEL_IN;
        if (acc) begin
          buf_we  = !eff_short && (eff_idx < CAP_IDX);
          cap_cur = eff_short ? (eff_idx == '0) : (eff_idx == CAP_IDX);
          short_d = eff_short;
          last_d  = eff_last;
          cnt_d   = eff_idx + CNT_W'(1);
          if (at_end) begin
            cnt_d = '0;
            if (!eff_short) begin
              state_d = ST_REPLAY;
              rcnt_d  = '0;
            end else begin
              load_prev = 1'b1;
              if (eff_last) begin
                state_d = ST_TAIL;
              end
            end
          end
        end
      end
      ST_REPLAY: begin
        emit = 1'b1;
        sel  = SEL_BUF;
        if (adv) begin
          rcnt_d = rcnt_q + GI_W'(1);
          if (rcnt_q == GI_END) begin
            rcnt_d    = '0;
            load_prev = 1'b1;
            state_d   = last_q ? ST_TAIL : ST_PASS;
          end
        end
      end
      ST_TAIL: begin
        emit = 1'b1;
        sel  = SEL_TAIL;
        if (adv) begin
          clr_prev = 1'b1;
          state_d  = ST_PASS;
        end
      end
      default: begin
        state_d = ST_PASS;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PASS;
      cnt_q   <= '0;
      rcnt_q  <= '0;
      short_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rcnt_q  <= rcnt_d;
      short_q <= short_d;
      last_q  <= last_d;
    end
  end
endmodule

// File: rtl/gi_postfix_window.sv
`timescale 1ns/1ps
// Guard-interval postfix generator with one-sample overlap window.
module gi_postfix_window
  import gpw_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SYM_LEN   = 64,
  parameter int GI_LEN    = 16,
  parameter int SHORT_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sos,
  input  logic              in_short,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_re,
  input  logic [DATA_W-1:0] in_im,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_re,
  output logic [DATA_W-1:0] out_im
);
  localparam int PW   = 2 * DATA_W;
  localparam int GI_W = $clog2(GI_LEN);

  logic [1:0]      rst_pipe;
  logic            rst_int_n;
  logic            adv;
  logic            emit;
  gpw_sel_e        sel;
  logic            buf_we;
  logic [GI_W-1:0] buf_waddr;
  logic [GI_W-1:0] buf_raddr;
  logic            cap_cur;
  logic            load_prev;
  logic            clr_prev;

  logic [PW-1:0]   in_data;
  logic [PW-1:0]   buf_rdata;
  logic [PW-1:0]   cur_cont_q;
  logic [PW-1:0]   prev_cont_q;
  logic [PW-1:0]   win_a;
  logic [PW-1:0]   win_y;
  logic [PW-1:0]   next_data;
  logic [PW-1:0]   out_data_q;
  logic            out_valid_q;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  assign in_data = {in_re, in_im};
  assign adv     = !out_valid_q || out_ready;

  gpw_ctrl #(
    .SYM_LEN  (SYM_LEN),
    .GI_LEN   (GI_LEN),
    .SHORT_LEN(SHORT_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_valid (in_valid),
    .in_sos   (in_sos),
    .in_short (in_short),
    .in_last  (in_last),
    .adv      (adv),
    .in_ready (in_ready),
    .emit     (emit),
    .sel      (sel),
    .buf_we   (buf_we),
    .buf_waddr(buf_waddr),
    .buf_raddr(buf_raddr),
    .cap_cur  (cap_cur),
    .load_prev(load_prev),
    .clr_prev (clr_prev)
  );

  gpw_gi_buf #(
    .WIDTH(PW),
    .DEPTH(GI_LEN)
  ) u_buf (
    .clk  (clk),
    .we   (buf_we),
    .waddr(buf_waddr),
    .wdata(in_data),
    .raddr(buf_raddr),
    .rdata(buf_rdata)
  );

  // One shared averager: the window edge uses the input sample, the tail uses zero.
  assign win_a = (sel == SEL_TAIL) ? '0 : in_data;

  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    gpw_half_sum #(.W(DATA_W)) u_avg (
      .a(win_a[lane*DATA_W +: DATA_W]),
      .b(prev_cont_q[lane*DATA_W +: DATA_W]),
      .y(win_y[lane*DATA_W +: DATA_W])
    );
  end

  always_comb begin
    unique case (sel)
      SEL_IN:   next_data = in_data;
      SEL_WIN:  next_data = win_y;
      SEL_BUF:  next_data = buf_rdata;
      SEL_TAIL: next_data = win_y;
      default:  next_data = in_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cur_cont_q  <= '0;
      prev_cont_q <= '0;
    end else begin
      if (cap_cur) begin
        cur_cont_q <= in_data;
      end
      if (clr_prev) begin
        prev_cont_q <= '0;
      end else if (load_prev) begin
        prev_cont_q <= cur_cont_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      if (adv) begin
        out_valid_q <= emit;
      end
      if (adv && emit) begin
        out_data_q <= next_data;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_re    = out_data_q[PW-1:DATA_W];
  assign out_im    = out_data_q[DATA_W-1:0];
endmodule

// File: rtl/gi_postfix_window_chk.sv
`timescale 1ns/1ps
// Port-level properties of the postfix/window unit.
module gi_postfix_window_chk #(
  parameter int DATA_W    = 16,
  parameter int SYM_LEN   = 64,
  parameter int SHORT_LEN = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_sos,
  input logic              in_short,
  input logic              in_last,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_re,
  input logic [DATA_W-1:0] out_im
);
  localparam int CW = $clog2(SYM_LEN) + 1;

  logic [CW-1:0] idx_q;
  logic          short_q;
  logic          last_q;
  logic [CW-1:0] idx_now;
  logic          short_now;
  logic          last_now;
  logic          take;
  logic          long_done;
  logic          short_done_mid;

  assign idx_now        = in_sos ? '0 : idx_q;
  assign short_now      = in_sos ? in_short : short_q;
  assign last_now       = in_sos ? in_last : last_q;
  assign take           = in_valid && in_ready;
  assign long_done      = take && !short_now && (idx_now == CW'(SYM_LEN - 1));
  assign short_done_mid = take && short_now && !last_now && (idx_now == CW'(SHORT_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      short_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (take) begin
      idx_q   <= idx_now + CW'(1);
      short_q <= short_now;
      last_q  <= last_now;
    end
  end

  AST_OUT_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);  // R9
  AST_OUT_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_re) && $stable(out_im)));  // R9
  AST_READY_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid || out_ready));  // R9
  AST_REPLAY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    long_done |=> !in_ready);  // R3
  AST_SHORT_NO_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    short_done_mid |=> (in_ready == (!out_valid || out_ready)));  // R8
endmodule

bind gi_postfix_window gi_postfix_window_chk #(
  .DATA_W   (DATA_W),
  .SYM_LEN  (SYM_LEN),
  .SHORT_LEN(SHORT_LEN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_sos   (in_sos),
  .in_short (in_short),
  .in_last  (in_last),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_re   (out_re),
  .out_im   (out_im)
);

// File: tb/gi_postfix_window_test.sv
`timescale 1ns/1ps
module gi_postfix_window_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sos = 1'b0;
  logic        in_short = 1'b0;
  logic        in_last = 1'b0;
  logic [15:0] in_re = '0;
  logic [15:0] in_im = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_re;
  logic [15:0] out_im;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    exp_re[$];
  int    exp_im[$];
  string exp_tag[$];
  int    prev_re = 0;
  int    prev_im = 0;
  bit    frame_open = 1'b0;
  bit    bp_mode = 1'b0;
  bit    noisy = 1'b0;
  int    last_stall = 0;

  always #2 clk = ~clk;

  gi_postfix_window uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_sos(in_sos), .in_short(in_short), .in_last(in_last),
    .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im)
  );

  function automatic int avg2(int a, int b);
    int s;
    s = a + b;
    return s >>> 1;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(int re, int im, string tag);
    exp_re.push_back(re);
    exp_im.push_back(im);
    exp_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    out_ready <= bp_mode ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  // Reference comparison on every clock, away from the edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (exp_re.size() == 0) begin
          check(1'b0, "R2", "unexpected output sample", int'($signed(out_re)), 0);
        end else begin
          int    er;
          int    ei;
          string tg;
          er = exp_re.pop_front();
          ei = exp_im.pop_front();
          tg = exp_tag.pop_front();
          check(int'($signed(out_re)) == er, tg, "out_re", int'($signed(out_re)), er);
          check(int'($signed(out_im)) == ei, tg, "out_im", int'($signed(out_im)), ei);
        end
      end
    end
  end

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic send_sample(int re, int im, bit sos, bit sh, bit la, output int stall);
    bit ok;
    in_valid = 1'b1;
    in_re    = 16'(re);
    in_im    = 16'(im);
    in_sos   = sos;
    in_short = sh;
    in_last  = la;
    stall    = 0;
    ok       = 1'b0;
    while (!ok) begin
      #1;
      ok = in_ready;
      @(negedge clk);
      if (!ok) stall++;
    end
    in_valid = 1'b0;
  endtask

  task automatic send_symbol(bit sh, bit la, int mode);
    int n;
    int sr[64];
    int si[64];
    int st;
    n = sh ? 16 : 64;
    for (int i = 0; i < n; i++) begin
      case (mode)
        1:       begin sr[i] = 32767;  si[i] = -32768; end
        2:       begin sr[i] = -32768; si[i] = 32767;  end
        default: begin
          sr[i] = int'($urandom_range(0, 65535)) - 32768;
          si[i] = int'($urandom_range(0, 65535)) - 32768;
        end
      endcase
    end
    // R4 window edge; R6 when the frame just started (previous value is zero)
    push(avg2(sr[0], prev_re), avg2(si[0], prev_im), frame_open ? "R4" : "R6");
    for (int i = 1; i < n; i++) push(sr[i], si[i], sh ? "R8" : "R2");
    if (!sh) begin
      for (int i = 0; i < 16; i++) push(sr[i], si[i], "R2");
    end
    // R5 continuation source
    prev_re = sh ? sr[0] : sr[16];
    prev_im = sh ? si[0] : si[16];
    if (la) begin
      push(avg2(0, prev_re), avg2(0, prev_im), "R7");
      prev_re = 0;
      prev_im = 0;
    end
    frame_open = !la;
    for (int i = 0; i < n; i++) begin
      bit fs;
      bit fl;
      // R10: flags off the start sample are noise
      fs = (i == 0) ? sh : (noisy ? 1'($urandom_range(0, 1)) : 1'b0);
      fl = (i == 0) ? la : (noisy ? 1'($urandom_range(0, 1)) : 1'b0);
      send_sample(sr[i], si[i], i == 0, fs, fl, st);
      if (i == 0) last_stall = st;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    @(negedge clk);

    // Frame A: long symbols, no back-pressure
    send_symbol(1'b0, 1'b0, 0);
    send_symbol(1'b0, 1'b0, 0);
    check(last_stall == 16, "R3", "stall after long symbol", last_stall, 16);
    send_symbol(1'b0, 1'b1, 0);
    check(last_stall == 16, "R3", "stall after long symbol", last_stall, 16);

    // Frame B: short symbols, full-scale window values
    send_symbol(1'b1, 1'b0, 0);
    check(last_stall == 17, "R7", "stall after long last symbol", last_stall, 17);
    send_symbol(1'b1, 1'b0, 1);
    check(last_stall == 0, "R8", "stall after short symbol", last_stall, 0);
    send_symbol(1'b0, 1'b0, 1);
    check(last_stall == 0, "R8", "stall after short symbol", last_stall, 0);
    send_symbol(1'b0, 1'b1, 2);
    check(last_stall == 16, "R3", "stall after long symbol", last_stall, 16);

    // Frame C: random back-pressure and noisy flags
    bp_mode = 1'b1;
    noisy   = 1'b1;
    for (int k = 0; k < 6; k++) send_symbol(1'(k % 2), 1'b0, 0);
    send_symbol(1'b1, 1'b1, 0);
    send_symbol(1'b0, 1'b0, 0);
    send_symbol(1'b0, 1'b1, 0);

    for (int w = 0; w < 3000 && exp_re.size() != 0; w++) @(negedge clk);
    check(exp_re.size() == 0, "R9", "samples still owed", exp_re.size(), 0);
    bp_mode = 1'b0;
    repeat (20) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule